// File: doc/BRIEF.md
# Dual Time Alarm Matcher

This block watches a running BCD time and calendar and raises a flag when the time matches either of two alarm settings that software has programmed. Each alarm has six settings: seconds, minutes, hours, date, month and day of week. Every setting is a byte. Its top bit says whether that field takes part in the match, and the seven low bits hold the BCD value to compare. A field whose top bit is clear is a don't-care. If an alarm has no field switched on, it stays silent. Switching on day-of-week, hours and minutes gives a weekly alarm. Switching on hours and minutes alone gives a daily alarm.

The comparison happens only on cycles where the once-per-second strobe from the time counter is high. A match therefore sets its flag once per matching second. Each flag stays set until a status read clears it. The read is framed by two strobes from the serial interface. A begin strobe captures which flags are set at that moment. A finish strobe, issued when the last data bit of the read completes, clears only the captured flags. An alarm that fires while the read is in progress survives the read. An active-low interrupt output can be switched on to signal that any flag is set, so software does not have to poll.

Top module: `dual_alarm_matcher`

## Requirements
- R1: A synchronous reset clears both flags and every alarm setting byte, including its enable bit. After reset the status byte is 0x00 and `irq_n` is 1.
- R2: A write with `cfg_we` high loads `cfg_wdata` into the setting chosen by `cfg_alarm` (0 or 1) and `cfg_field`. The field codes are 0 seconds, 1 minutes, 2 hours, 3 date, 4 month and 5 day of week. Field codes 6 and 7 change nothing.
- R3: On a clock edge where `tick_1hz` is high, an alarm sets its flag if it has at least one field switched on and every switched-on field's bits 6:0 equal the matching time input. Switched-off fields are ignored. With `tick_1hz` low, no flag is set.
- R4: An alarm with all six enable bits at 0 never sets its flag, whatever its values and the time.
- R5: The status byte shows alarm 0's flag at bit 5 and alarm 1's flag at bit 6. All other bits read 0.
- R6: A flag that is set stays set on every edge without `sr_rd_finish`.
- R7: `sr_rd_begin` captures the flags present before that edge. `sr_rd_finish` clears exactly the captured flags and discards the capture. A flag set on the begin edge, during the read, or on the finish edge itself remains 1.
- R8: `irq_n` is 0 exactly when `irq_en` is 1 and at least one flag is set. It follows the flags without further delay.
- R9: `sr_rd_finish` with no earlier `sr_rd_begin` since the last finish clears nothing. If both strobes are high on the same edge, the finish acts and the begin is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_1hz | input | 1 | One-cycle strobe each second; enables comparison |
| now_sec | input | 7 | Current seconds, BCD |
| now_min | input | 7 | Current minutes, BCD |
| now_hour | input | 7 | Current hours, BCD |
| now_date | input | 7 | Current date, BCD |
| now_month | input | 7 | Current month, BCD |
| now_dow | input | 7 | Current day of week |
| cfg_we | input | 1 | Setting write strobe |
| cfg_alarm | input | 1 | Alarm selected for write |
| cfg_field | input | 3 | Field code selected for write |
| cfg_wdata | input | 8 | Enable bit 7, compare value bits 6:0 |
| sr_rd_begin | input | 1 | Status read starts |
| sr_rd_finish | input | 1 | Last data bit of the status read completes |
| irq_en | input | 1 | Enables the interrupt output |
| status_o | output | 8 | Status byte with the flags at bits 6 and 5 |
| irq_n | output | 1 | Interrupt, active low |

## Verification
A setting write, a matching tick and a read strobe each take effect at the clock edge where they are sampled. A flag changes at that edge. `status_o` and `irq_n` are combinational from the flag registers, so they show the new value straight after the same edge, and a change of `irq_en` shows on `irq_n` at once. The bench drives every input on the falling edge. It updates its own model of the settings, flags and read capture from those inputs at the rising edge. It compares both outputs on the next falling edge, which is half a cycle after the edge that counts. This keeps every comparison clear of the active edge and of process ordering.

// File: rtl/tam_pkg.sv
package tam_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned FIELD_CNT = 6;
  localparam int unsigned ALARM_CNT = 2;
  localparam int unsigned FLAG_LSB  = 5;
  localparam int unsigned SEL_W     = 3;
  localparam int unsigned ALM_W     = 1;
endpackage

// File: rtl/tam_bank.sv
module tam_bank #(
  parameter int unsigned ALARM_IDX = 0,
  parameter int unsigned FN        = tam_pkg::FIELD_CNT,
  parameter int unsigned BW        = tam_pkg::BYTE_W,
  parameter int unsigned SW        = tam_pkg::SEL_W,
  parameter int unsigned AW        = tam_pkg::ALM_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [AW-1:0]          wr_alarm,
  input  logic [SW-1:0]          wr_field,
  input  logic [BW-1:0]          wr_data,
  output logic [FN-1:0][BW-1:0]  cfg_o
);
  logic bank_sel;
  assign bank_sel = wr_en && (wr_alarm == AW'(ALARM_IDX));

  for (genvar f = 0; f < FN; f++) begin : g_field
    always_ff @(posedge clk) begin
      if (rst) begin
        cfg_o[f] <= '0;
      end else if (bank_sel && (wr_field == SW'(f))) begin
        cfg_o[f] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/tam_match.sv
module tam_match #(
  parameter int unsigned FN = tam_pkg::FIELD_CNT,
  parameter int unsigned BW = tam_pkg::BYTE_W
) (
  input  logic                   tick,
  input  logic [FN-1:0][BW-1:0]  cfg,
  input  logic [FN-1:0][BW-2:0]  now,
  output logic                   hit,
  output logic                   en_any
);
  localparam int unsigned EN_BIT = BW - 1;

  function automatic logic [FN-1:0] enables(input logic [FN-1:0][BW-1:0] c);
    logic [FN-1:0] e;
    for (int f = 0; f < FN; f++) e[f] = c[f][EN_BIT];
    return e;
  endfunction

  function automatic logic [FN-1:0] disagree(input logic [FN-1:0][BW-1:0] c,
                                             input logic [FN-1:0][BW-2:0] t);
    logic [FN-1:0] d;
    for (int f = 0; f < FN; f++) d[f] = c[f][EN_BIT] && (c[f][BW-2:0] != t[f]);
    return d;
  endfunction

  logic [FN-1:0] en_vec;
  logic [FN-1:0] miss_vec;

  assign en_vec   = enables(cfg);
  assign miss_vec = disagree(cfg, now);
  assign en_any   = |en_vec;
  assign hit      = tick && en_any && (miss_vec == '0);
endmodule

// File: rtl/tam_flags.sv
module tam_flags #(
  parameter int unsigned AN = tam_pkg::ALARM_CNT
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AN-1:0] hit,
  input  logic          rd_begin,
  input  logic          rd_finish,
  output logic [AN-1:0] flags,
  output logic [AN-1:0] snap
);
  function automatic logic [AN-1:0] next_flags(input logic [AN-1:0] cur,
                                               input logic [AN-1:0] cap,
                                               input logic           fin,
                                               input logic [AN-1:0] set);
    logic [AN-1:0] clr;
    clr = fin ? cap : '0;
    return (cur & ~clr) | set;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
      snap  <= '0;
    end else begin
      flags <= next_flags(flags, snap, rd_finish, hit);
      if (rd_finish)     snap <= '0;
      else if (rd_begin) snap <= flags;
    end
  end
endmodule

// File: rtl/dual_alarm_matcher.sv
module dual_alarm_matcher #(
  parameter int unsigned FN = tam_pkg::FIELD_CNT,
  parameter int unsigned BW = tam_pkg::BYTE_W,
  parameter int unsigned AN = tam_pkg::ALARM_CNT,
  parameter int unsigned SW = tam_pkg::SEL_W,
  parameter int unsigned AW = tam_pkg::ALM_W,
  parameter int unsigned FL = tam_pkg::FLAG_LSB
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_1hz,
  input  logic [BW-2:0] now_sec,
  input  logic [BW-2:0] now_min,
  input  logic [BW-2:0] now_hour,
  input  logic [BW-2:0] now_date,
  input  logic [BW-2:0] now_month,
  input  logic [BW-2:0] now_dow,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_alarm,
  input  logic [SW-1:0] cfg_field,
  input  logic [BW-1:0] cfg_wdata,
  input  logic          sr_rd_begin,
  input  logic          sr_rd_finish,
  input  logic          irq_en,
  output logic [BW-1:0] status_o,
  output logic          irq_n
);
  logic [FN-1:0][BW-2:0] now_vec;
  logic [AN-1:0]         alarm_hit;
  logic [AN-1:0]         alarm_en_any;
  logic [AN-1:0]         flag_q;
  logic [AN-1:0]         snap_q;

  assign now_vec = {now_dow, now_month, now_date, now_hour, now_min, now_sec};

  for (genvar a = 0; a < AN; a++) begin : g_alarm
    logic [FN-1:0][BW-1:0] cfg_q;

    tam_bank #(.ALARM_IDX(a), .FN(FN), .BW(BW), .SW(SW), .AW(AW)) u_bank (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (cfg_we),
      .wr_alarm (cfg_alarm),
      .wr_field (cfg_field),
      .wr_data  (cfg_wdata),
      .cfg_o    (cfg_q)
    );

    tam_match #(.FN(FN), .BW(BW)) u_match (
      .tick   (tick_1hz),
      .cfg    (cfg_q),
      .now    (now_vec),
      .hit    (alarm_hit[a]),
      .en_any (alarm_en_any[a])
    );
  end

  tam_flags #(.AN(AN)) u_flags (
    .clk       (clk),
    .rst       (rst),
    .hit       (alarm_hit),
    .rd_begin  (sr_rd_begin),
    .rd_finish (sr_rd_finish),
    .flags     (flag_q),
    .snap      (snap_q)
  );

  always_comb begin
    status_o = '0;
    status_o[FL +: AN] = flag_q;
  end

  assign irq_n = !(irq_en && (flag_q != '0));
endmodule

// File: rtl/tam_checker.sv
module tam_checker #(
  parameter int unsigned AN = 2,
  parameter int unsigned BW = 8,
  parameter int unsigned FL = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          tick,
  input logic          rd_finish,
  input logic          irq_en,
  input logic          irq_n,
  input logic [BW-1:0] status,
  input logic [AN-1:0] hit,
  input logic [AN-1:0] en_any
);
  localparam logic [BW-1:0] FLAG_MASK = BW'(((1 << AN) - 1) << FL);

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (status[FL +: AN] == '0)); // R1
  AST_NO_TICK_NO_SET: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ((status[FL +: AN] & ~$past(status[FL +: AN])) == '0)); // R3
  AST_HIT_LATCHES: assert property (@(posedge clk) disable iff (rst)
    (hit != '0) |=> ((status[FL +: AN] & $past(hit)) == $past(hit))); // R7
  AST_SILENT_WITHOUT_ENABLE: assert property (@(posedge clk) disable iff (rst)
    ((hit & ~en_any) == '0)); // R4
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    !rd_finish |=> ((~status[FL +: AN] & $past(status[FL +: AN])) == '0)); // R6
  AST_OTHER_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
    ((status & ~FLAG_MASK) == '0)); // R5
  AST_IRQ_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    (irq_en && (status[FL +: AN] != '0)) |-> !irq_n); // R8
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
    !irq_en |-> irq_n); // R8
endmodule

bind dual_alarm_matcher tam_checker #(.AN(AN), .BW(BW), .FL(FL)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .tick      (tick_1hz),
  .rd_finish (sr_rd_finish),
  .irq_en    (irq_en),
  .irq_n     (irq_n),
  .status    (status_o),
  .hit       (alarm_hit),
  .en_any    (alarm_en_any)
);

// File: tb/tb_dual_alarm_matcher.sv
`timescale 1ns/1ps
module tb_dual_alarm_matcher;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic [6:0] tnow [6];
  logic       cfg_we = 1'b0;
  logic       cfg_alarm = 1'b0;
  logic [2:0] cfg_field = 3'd0;
  logic [7:0] cfg_wdata = 8'd0;
  logic       rd_begin = 1'b0;
  logic       rd_finish = 1'b0;
  logic       irq_en = 1'b0;
  logic [7:0] status_o;
  logic       irq_n;

  int n_tests = 0;
  int n_fail  = 0;
  string cur_req = "R1";

  logic [7:0] m_cfg [2][6];
  logic [1:0] m_flags, m_snap;

  always #5 clk = ~clk;

  dual_alarm_matcher dut (
    .clk(clk), .rst(rst), .tick_1hz(tick),
    .now_sec(tnow[0]), .now_min(tnow[1]), .now_hour(tnow[2]),
    .now_date(tnow[3]), .now_month(tnow[4]), .now_dow(tnow[5]),
    .cfg_we(cfg_we), .cfg_alarm(cfg_alarm), .cfg_field(cfg_field), .cfg_wdata(cfg_wdata),
    .sr_rd_begin(rd_begin), .sr_rd_finish(rd_finish), .irq_en(irq_en),
    .status_o(status_o), .irq_n(irq_n)
  );

  function automatic logic model_hit(input int a);
    logic any, ok;
    any = 1'b0; ok = 1'b1;
    if (!tick) return 1'b0;
    for (int f = 0; f < 6; f++) begin
      if (m_cfg[a][f][7]) begin
        any = 1'b1;
        if (m_cfg[a][f][6:0] != tnow[f]) ok = 1'b0;
      end
    end
    return any && ok;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cycle();
    logic [1:0] hits, nf, ns;
    hits = {model_hit(1), model_hit(0)};
    if (rst) begin
      nf = '0; ns = '0;
    end else begin
      nf = (m_flags & ~(rd_finish ? m_snap : 2'b00)) | hits;
      ns = rd_finish ? 2'b00 : (rd_begin ? m_flags : m_snap);
    end
    @(posedge clk);
    if (rst) begin
      for (int a = 0; a < 2; a++) for (int f = 0; f < 6; f++) m_cfg[a][f] = 8'h00;
    end else if (cfg_we && cfg_field < 3'd6) begin
      m_cfg[cfg_alarm][cfg_field] = cfg_wdata;
    end
    m_flags = nf; m_snap = ns;
    @(negedge clk);
    check(cur_req, status_o, {1'b0, m_flags, 5'b0});
    check("R8", {7'b0, irq_n}, {7'b0, !(irq_en && m_flags != 2'b00)});
    tick = 1'b0; cfg_we = 1'b0; rd_begin = 1'b0; rd_finish = 1'b0;
  endtask

  task automatic wr(input logic a, input logic [2:0] f, input logic [7:0] d);
    cfg_we = 1'b1; cfg_alarm = a; cfg_field = f; cfg_wdata = d;
    cycle();
  endtask

  task automatic set_time(input logic [6:0] s, input logic [6:0] mi, input logic [6:0] h,
                          input logic [6:0] d, input logic [6:0] mo, input logic [6:0] w);
    tnow[0] = s; tnow[1] = mi; tnow[2] = h; tnow[3] = d; tnow[4] = mo; tnow[5] = w;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    m_flags = '0; m_snap = '0;
    for (int a = 0; a < 2; a++) for (int f = 0; f < 6; f++) m_cfg[a][f] = 8'h00;
    set_time(7'h00, 7'h00, 7'h00, 7'h01, 7'h01, 7'h00);
    @(negedge clk);
    cycle(); cycle();
    rst = 1'b0;
    cur_req = "R1";
    cycle();
    check("R1", status_o, 8'h00);
    check("R1", {7'b0, irq_n}, 8'h01);

    // R2: weekly alarm on alarm 0: day 3, 08:30
    cur_req = "R2";
    wr(1'b0, 3'd1, 8'hB0);
    wr(1'b0, 3'd2, 8'h88);
    wr(1'b0, 3'd5, 8'h83);
    // R3: wrong day with tick does not fire
    cur_req = "R3";
    set_time(7'h12, 7'h30, 7'h08, 7'h15, 7'h06, 7'h04);
    tick = 1'b1; cycle();
    check("R3", status_o, 8'h00);
    // R3: matching time without tick does not fire
    tnow[5] = 7'h03;
    cycle();
    check("R3", status_o, 8'h00);
    // R3: matching time with tick fires alarm 0 -> bit 5 (R5)
    tick = 1'b1; cycle();
    check("R5", status_o, 8'h20);
    check("R8", {7'b0, irq_n}, 8'h01);
    irq_en = 1'b1; #1;
    check("R8", {7'b0, irq_n}, 8'h00);
    // R6: flag holds over idle ticks
    cur_req = "R6";
    tnow[1] = 7'h31;
    for (int i = 0; i < 4; i++) begin tick = 1'b1; cycle(); end
    check("R6", status_o, 8'h20);

    // R7: alarm 1 daily 08:31 fires during a read and survives it
    cur_req = "R7";
    wr(1'b1, 3'd1, 8'hB1);
    wr(1'b1, 3'd2, 8'h88);
    rd_begin = 1'b1; cycle();
    tick = 1'b1; cycle();
    check("R7", status_o, 8'h60);
    rd_finish = 1'b1; cycle();
    check("R7", status_o, 8'h40);
    // R7: set on the finish edge beats the clear
    rd_begin = 1'b1; cycle();
    rd_finish = 1'b1; tick = 1'b1; cycle();
    check("R7", status_o, 8'h40);
    rd_begin = 1'b1; cycle();
    rd_finish = 1'b1; cycle();
    check("R7", status_o, 8'h00);
    check("R8", {7'b0, irq_n}, 8'h01);

    // R9: finish without begin clears nothing; both strobes together: finish wins
    cur_req = "R9";
    tick = 1'b1; cycle();
    check("R9", status_o, 8'h40);
    rd_finish = 1'b1; cycle();
    check("R9", status_o, 8'h40);
    rd_begin = 1'b1; rd_finish = 1'b1; cycle();
    rd_finish = 1'b1; cycle();
    check("R9", status_o, 8'h40);
    rd_begin = 1'b1; cycle();
    rd_finish = 1'b1; cycle();
    check("R9", status_o, 8'h00);

    // R4: values equal to the time but every enable off -> silent
    cur_req = "R4";
    for (int f = 0; f < 6; f++) wr(1'b0, 3'(f), {1'b0, tnow[f]});
    for (int f = 0; f < 6; f++) wr(1'b1, 3'(f), {1'b0, tnow[f]});
    for (int i = 0; i < 3; i++) begin tick = 1'b1; cycle(); end
    check("R4", status_o, 8'h00);
    // R2: field codes 6 and 7 write nothing
    cur_req = "R2";
    wr(1'b0, 3'd6, {1'b1, tnow[0]});
    wr(1'b1, 3'd7, {1'b1, tnow[0]});
    tick = 1'b1; cycle();
    check("R2", status_o, 8'h00);

    // R3: constrained random run
    cur_req = "R3";
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4000; i++) begin
      for (int f = 0; f < 6; f++) tnow[f] = 7'($urandom_range(0, 1));
      tick      = ($urandom_range(0, 3) != 0);
      cfg_we    = ($urandom_range(0, 7) == 0);
      cfg_alarm = 1'($urandom_range(0, 1));
      cfg_field = 3'($urandom_range(0, 7));
      cfg_wdata = {($urandom_range(0, 2) == 0), 7'($urandom_range(0, 1))};
      rd_begin  = ($urandom_range(0, 9) == 0);
      rd_finish = ($urandom_range(0, 9) == 0);
      irq_en    = ($urandom_range(0, 3) != 0);
      cycle();
    end

    // R1: reset mid-run clears flags and settings
    cur_req = "R1";
    wr(1'b0, 3'd0, {1'b1, tnow[0]});
    tick = 1'b1; cycle();
    rst = 1'b1; cycle();
    rst = 1'b0;
    tick = 1'b1; cycle();
    check("R1", status_o, 8'h00);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule